// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide host-side front end of a multi-channel interval timer. Four addresses are decoded. Addresses 0 to NCH-1 are the data ports of the channels, and address 3 takes control words. A control word can do one of three things: it configures a channel, it freezes a channel's running count, or it issues a combined read-back that can freeze count and status for several channels at once.

Each channel keeps its own write byte-order state and read byte-order state. The 16-bit load value is handed to the counting logic in one piece, together with the channel's mode, access and BCD fields. Reads return a frozen status byte first, then a frozen count, and otherwise the live count taken from the counter. The counting logic itself lies outside this block. The block takes each channel's live count and output level as inputs.

Top module: `itmr_regif`

## Requirements
- R1: After a synchronous reset, every channel has access mode 3, mode 0 and BCD 0. `rd_data` is 0x00, and no load strobe is active.
- R2: A control word with channel field (bits 7:6) below 3 and access field (bits 5:4) non-zero stores the following in that channel: the access field, the mode field (bits 3:1) and the BCD bit (bit 0). It also returns that channel's read and write byte-order states to the low byte.
- R3: A data write in access mode 1 loads {0x00, byte}. In access mode 2 it loads {byte, 0x00}. Each data write loads at most one channel. Load strobes are one-cycle pulses in the cycle after the write.
- R4: In access mode 3, the first data byte is held and produces no load. The second byte produces a load of {second, first}, and the state then expects a low byte again.
- R5: A control word with access field 0 freezes the addressed channel's live count and leaves its configuration unchanged.
- R6: A count-freeze or status-freeze request is ignored while an earlier frozen value of the same kind is still unread.
- R7: A control word with channel field 3 is a read-back. Bit 1+n selects channel n. Bit 5 at 0 freezes the counts, and bit 4 at 0 freezes the status bytes.
- R8: The status byte is {output level, 0, access[1:0], mode[2:0], bcd}.
- R9: A channel read returns a frozen status first, if one exists, then the frozen count. In access mode 3 the frozen count is returned low byte then high byte. In modes 1 and 2 only the selected byte is returned.
- R10: With nothing frozen, a read returns the live count. Mode 1 gives the low byte, mode 2 the high byte, and mode 3 alternates low then high.
- R11: A read of the control address returns 0x00. A read strobe in the same cycle as a write strobe is ignored, and `rd_data` holds its value.
- R12: `rd_data` is registered. It changes only in the cycle after an accepted read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Port select: channels 0..NCH-1, control at 3 |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| cnt_live | input | NCH*16 | Live count of each channel |
| out_lvl | input | NCH | Output level of each channel |
| load_stb | output | NCH | One-cycle load pulse per channel |
| load_val | output | NCH*16 | Load value per channel |
| ch_mode | output | NCH*3 | Operating mode per channel |
| ch_acc | output | NCH*2 | Access mode per channel |
| ch_bcd | output | NCH | BCD flag per channel |

## Verification
The bench builds the block with the default three channels. The read-back command can then select one, two or all three channels in a single word, which exercises mixed status-then-count sequences across channels that each sit in a different access mode. Because three channels are present, the bench can also check that byte-order state and freeze state stay local to each channel while another channel is being reconfigured or read.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [1:0] ACC_CMD  = 2'd0;
  localparam logic [1:0] ACC_LO   = 2'd1;
  localparam logic [1:0] ACC_HI   = 2'd2;
  localparam logic [1:0] ACC_WORD = 2'd3;

  typedef enum logic [1:0] {CL_NONE, CL_LO, CL_HI, CL_WORD} clat_e;

  typedef struct packed {
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;
endpackage

// File: rtl/itmr_cmd_dec.sv
module itmr_cmd_dec
  import itmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NCH-1:0]    dat_we,
  output logic [NCH-1:0]    cfg_we,
  output logic [NCH-1:0]    lat_cnt,
  output logic [NCH-1:0]    lat_st
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic       is_ctl;
  logic       is_rb;
  logic [1:0] sel;
  logic [1:0] acc;

  assign is_ctl = wr_en && (addr == CTRL_ADDR);
  assign sel    = wr_data[7:6];
  assign acc    = wr_data[5:4];
  assign is_rb  = is_ctl && (sel == 2'd3);

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    logic hit;
    assign hit        = is_ctl && !is_rb && (sel == 2'(n));
    assign dat_we[n]  = wr_en && (addr == 2'(n));
    assign cfg_we[n]  = hit && (acc != ACC_CMD);
    assign lat_cnt[n] = (hit && (acc == ACC_CMD)) ||
                        (is_rb && wr_data[1+n] && !wr_data[5]);
    assign lat_st[n]  = is_rb && wr_data[1+n] && !wr_data[4];
  end
endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              dat_we,
  input  logic              rd_hit,
  input  logic              lat_cnt,
  input  logic              lat_st,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CNT_W-1:0]  cnt_live,
  input  logic              out_lvl,
  output chcfg_t            cfg,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [BYTE_W-1:0] rd_byte
);
  logic              wph;
  logic              rph;
  logic [BYTE_W-1:0] hold;
  logic              stv;
  logic [BYTE_W-1:0] stat;
  clat_e             clst;
  logic [CNT_W-1:0]  clv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
      wph      <= 1'b0;
      rph      <= 1'b0;
      hold     <= '0;
      stv      <= 1'b0;
      stat     <= '0;
      clst     <= CL_NONE;
      clv      <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (cfg_we) begin
        cfg <= '{acc: wbyte[5:4], mode: wbyte[3:1], bcd: wbyte[0]};
        wph <= 1'b0;
        rph <= 1'b0;
      end
      if (lat_cnt && (clst == CL_NONE)) begin
        clv  <= cnt_live;
        clst <= (cfg.acc == ACC_LO) ? CL_LO :
                (cfg.acc == ACC_HI) ? CL_HI : CL_WORD;
      end
      if (lat_st && !stv) begin
        stv  <= 1'b1;
        stat <= {out_lvl, 1'b0, cfg.acc, cfg.mode, cfg.bcd};
      end
      if (dat_we) begin
        case (cfg.acc)
          ACC_LO: begin
            load_stb <= 1'b1;
            load_val <= CNT_W'(wbyte);
          end
          ACC_HI: begin
            load_stb <= 1'b1;
            load_val <= {wbyte, {BYTE_W{1'b0}}};
          end
          default: begin
            if (!wph) begin
              hold <= wbyte;
              wph  <= 1'b1;
            end else begin
              load_stb <= 1'b1;
              load_val <= {wbyte, hold};
              wph      <= 1'b0;
            end
          end
        endcase
      end
      if (rd_hit) begin
        if (stv) begin
          stv <= 1'b0;
        end else if (clst != CL_NONE) begin
          clst <= (clst == CL_WORD) ? CL_HI : CL_NONE;
        end else if (cfg.acc == ACC_WORD) begin
          rph <= ~rph;
        end
      end
    end
  end

  always_comb begin
    if (stv) begin
      rd_byte = stat;
    end else begin
      case (clst)
        CL_LO, CL_WORD: rd_byte = clv[BYTE_W-1:0];
        CL_HI:          rd_byte = clv[CNT_W-1:BYTE_W];
        default: begin
          if (cfg.acc == ACC_HI || (cfg.acc == ACC_WORD && rph))
            rd_byte = cnt_live[CNT_W-1:BYTE_W];
          else
            rd_byte = cnt_live[BYTE_W-1:0];
        end
      endcase
    end
  end

  AST_WORD_PAIR: assert property (@(posedge clk) disable iff (rst)
    (load_stb && cfg.acc == ACC_WORD) |-> $past(wph)); // R4
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && stv) |=> (!stv && $stable(clst))); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clst != CL_NONE && !rd_hit) |=> $stable(clv)); // R6
  AST_LATCH_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    lat_cnt |=> $stable(cfg)); // R5
endmodule

// File: rtl/itmr_regif.sv
module itmr_regif
  import itmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  input  logic [NCH*16-1:0]    cnt_live,
  input  logic [NCH-1:0]       out_lvl,
  output logic [NCH-1:0]       load_stb,
  output logic [NCH*16-1:0]    load_val,
  output logic [NCH*3-1:0]     ch_mode,
  output logic [NCH*2-1:0]     ch_acc,
  output logic [NCH-1:0]       ch_bcd
);
  logic [NCH-1:0]    dat_we;
  logic [NCH-1:0]    cfg_we;
  logic [NCH-1:0]    lat_cnt;
  logic [NCH-1:0]    lat_st;
  logic [NCH-1:0]    rd_hit;
  logic [BYTE_W-1:0] rd_byte [NCH];
  chcfg_t            cfg     [NCH];
  logic              rd_ok;
  logic [BYTE_W-1:0] rsel;

  assign rd_ok = rd_en && !wr_en;

  itmr_cmd_dec #(.NCH(NCH)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .dat_we  (dat_we),
    .cfg_we  (cfg_we),
    .lat_cnt (lat_cnt),
    .lat_st  (lat_st)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign rd_hit[n] = rd_ok && (addr == 2'(n));
    itmr_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we[n]),
      .dat_we   (dat_we[n]),
      .rd_hit   (rd_hit[n]),
      .lat_cnt  (lat_cnt[n]),
      .lat_st   (lat_st[n]),
      .wbyte    (wr_data),
      .cnt_live (cnt_live[n*CNT_W +: CNT_W]),
      .out_lvl  (out_lvl[n]),
      .cfg      (cfg[n]),
      .load_stb (load_stb[n]),
      .load_val (load_val[n*CNT_W +: CNT_W]),
      .rd_byte  (rd_byte[n])
    );
    assign ch_mode[n*3 +: 3] = cfg[n].mode;
    assign ch_acc[n*2 +: 2]  = cfg[n].acc;
    assign ch_bcd[n]         = cfg[n].bcd;
  end

  always_comb begin
    rsel = '0;
    for (int n = 0; n < NCH; n++)
      if (addr == 2'(n)) rsel = rd_byte[n];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_ok) rd_data <= rsel;
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> $stable(rd_data)); // R12
endmodule

// File: tb/itmr_regif_bench.sv
`timescale 1ns/1ps
module itmr_regif_bench;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic [NCH*16-1:0] cnt_live = '0;
  logic [NCH-1:0]    out_lvl = '0;
  logic [NCH-1:0]    load_stb;
  logic [NCH*16-1:0] load_val;
  logic [NCH*3-1:0]  ch_mode;
  logic [NCH*2-1:0]  ch_acc;
  logic [NCH-1:0]    ch_bcd;

  always #4 clk = ~clk;

  itmr_regif #(.NCH(NCH)) u_itmr_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cnt_live(cnt_live),
    .out_lvl(out_lvl), .load_stb(load_stb), .load_val(load_val),
    .ch_mode(ch_mode), .ch_acc(ch_acc), .ch_bcd(ch_bcd)
  );

  int total = 0, bad = 0;
  int m_acc[NCH], m_mode[NCH], m_bcd[NCH], m_wph[NCH], m_rph[NCH], m_hold[NCH];
  int m_stv[NCH], m_stat[NCH], m_cl[NCH], m_clv[NCH];
  int e_rd, e_ld[NCH], e_lv[NCH];
  int live[NCH];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_live(input int n, input int v);
    live[n] = v;
    cnt_live[n*16 +: 16] = 16'(v);
  endtask

  task automatic m_reset();
    for (int n = 0; n < NCH; n++) begin
      m_acc[n] = 3; m_mode[n] = 0; m_bcd[n] = 0; m_wph[n] = 0; m_rph[n] = 0;
      m_hold[n] = 0; m_stv[n] = 0; m_stat[n] = 0; m_cl[n] = 0; m_clv[n] = 0;
      e_ld[n] = 0; e_lv[n] = 0;
    end
    e_rd = 0;
  endtask

  task automatic m_lat_cnt(input int n);
    if (m_cl[n] == 0) begin
      m_clv[n] = live[n];
      m_cl[n] = (m_acc[n] == 1) ? 1 : (m_acc[n] == 2) ? 2 : 3;
    end
  endtask

  task automatic m_lat_st(input int n);
    if (m_stv[n] == 0) begin
      m_stv[n] = 1;
      m_stat[n] = (int'(out_lvl[n]) << 7) | (m_acc[n] << 4) | (m_mode[n] << 1) | m_bcd[n];
    end
  endtask

  // one clock: drive at negedge, predict, compare after the edge
  task automatic cyc(input bit w, input bit r, input int a, input int d, input string tag);
    wr_en = w; rd_en = r; addr = 2'(a); wr_data = 8'(d);
    for (int n = 0; n < NCH; n++) e_ld[n] = 0;
    if (w && a == 3) begin
      int sel, ac;
      sel = (d >> 6) & 3; ac = (d >> 4) & 3;
      if (sel == 3) begin
        for (int n = 0; n < NCH; n++)
          if (((d >> (1 + n)) & 1) != 0) begin
            if (((d >> 5) & 1) == 0) m_lat_cnt(n);
            if (((d >> 4) & 1) == 0) m_lat_st(n);
          end
      end else if (ac == 0) m_lat_cnt(sel);
      else begin
        m_acc[sel] = ac; m_mode[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
        m_wph[sel] = 0; m_rph[sel] = 0;
      end
    end else if (w) begin
      if (m_acc[a] == 1) begin e_ld[a] = 1; e_lv[a] = d & 255; end
      else if (m_acc[a] == 2) begin e_ld[a] = 1; e_lv[a] = (d & 255) << 8; end
      else if (m_wph[a] == 0) begin m_hold[a] = d & 255; m_wph[a] = 1; end
      else begin e_ld[a] = 1; e_lv[a] = ((d & 255) << 8) | m_hold[a]; m_wph[a] = 0; end
    end
    if (r && !w) begin
      if (a == 3) e_rd = 0;
      else if (m_stv[a] != 0) begin e_rd = m_stat[a]; m_stv[a] = 0; end
      else if (m_cl[a] == 1) begin e_rd = m_clv[a] & 255; m_cl[a] = 0; end
      else if (m_cl[a] == 2) begin e_rd = m_clv[a] >> 8; m_cl[a] = 0; end
      else if (m_cl[a] == 3) begin e_rd = m_clv[a] & 255; m_cl[a] = 2; end
      else if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rph[a] != 0)) begin
        e_rd = (live[a] >> 8) & 255;
        if (m_acc[a] == 3) m_rph[a] = 0;
      end else begin
        e_rd = live[a] & 255;
        if (m_acc[a] == 3) m_rph[a] = 1;
      end
    end
    @(posedge clk);
    #2;
    chk(tag, "rd_data", int'(rd_data), e_rd);
    for (int n = 0; n < NCH; n++) begin
      chk(tag, "load_stb", int'(load_stb[n]), e_ld[n]);
      if (e_ld[n] != 0) chk(tag, "load_val", int'(load_val[n*16 +: 16]), e_lv[n]);
      chk(tag, "ch_acc", int'(ch_acc[n*2 +: 2]), m_acc[n]);
      chk(tag, "ch_mode", int'(ch_mode[n*3 +: 3]), m_mode[n]);
      chk(tag, "ch_bcd", int'(ch_bcd[n]), m_bcd[n]);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d, input string tag); cyc(1, 0, a, d, tag); endtask
  task automatic rd(input int a, input string tag); cyc(0, 1, a, 0, tag); endtask

  bit done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    set_live(0, 16'h1234); set_live(1, 16'hABCD); set_live(2, 16'h0F0E);
    out_lvl = 3'b101;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc(0, 0, 0, 0, "R1");
    // R2 configure ch1: access 1, mode 2, bcd 1
    wr(3, 8'h55, "R2");
    // R3 low-only and high-only loads
    wr(1, 8'h77, "R3");
    wr(3, 8'hA6, "R2");
    wr(2, 8'h5A, "R3");
    // R10 live reads per access mode
    rd(1, "R10"); rd(2, "R10");
    // R4 word writes on ch0 (default access 3)
    wr(0, 8'h34, "R4"); wr(0, 8'h12, "R4");
    wr(0, 8'h11, "R4"); wr(3, 8'h30, "R2"); wr(0, 8'h22, "R4"); wr(0, 8'h33, "R4");
    // R10 alternating word read, reset by control word
    rd(0, "R10"); rd(0, "R10"); rd(0, "R10"); wr(3, 8'h30, "R2"); rd(0, "R10");
    // R5 counter freeze keeps configuration
    wr(3, 8'h00, "R5");
    set_live(0, 16'h5678);
    rd(0, "R5"); rd(0, "R5"); rd(0, "R10");
    // R6 second freeze ignored while first unread
    wr(3, 8'h40, "R6");
    set_live(1, 16'h1111);
    wr(3, 8'h40, "R6");
    rd(1, "R6"); rd(1, "R6");
    // R7 R8 R9 read-back of all three channels, count and status
    rd(0, "R10");
    wr(3, 8'hCE, "R7");
    set_live(0, 16'h9999); set_live(2, 16'h4444);
    rd(0, "R8"); rd(0, "R9"); rd(0, "R9");
    rd(2, "R8"); rd(2, "R9"); rd(2, "R10");
    rd(1, "R8"); rd(1, "R9"); rd(1, "R10");
    // R7 status-only read-back of ch0, then a repeated one while unread
    wr(3, 8'hE2, "R7"); out_lvl = 3'b000; wr(3, 8'hE2, "R6");
    rd(0, "R8"); rd(0, "R9");
    // R7 count-only read-back of ch1 and ch2
    wr(3, 8'hDC, "R7"); rd(2, "R9"); rd(1, "R9");
    // R11 control address read, read blocked by write
    rd(3, "R11");
    rd(1, "R10");
    cyc(1, 1, 1, 8'h3C, "R11");
    // R12 rd_data holds while idle
    cyc(0, 0, 0, 0, "R12"); cyc(0, 0, 2, 0, "R12");
    // R1 reset again mid-use
    rst = 1'b1; m_reset(); @(negedge clk); rst = 1'b0;
    cyc(0, 0, 0, 0, "R1");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule